// File: doc/BRIEF.md
# Memory-Mapped Level Interrupt Collector

This block gathers up to 128 level-sensitive request lines into one interrupt for the CPU. Each line has an 8-bit control field. Four fields are packed into each 32-bit control word, one field per byte lane. A field holds an enable (mask) bit and a two-bit priority level. While a line is high and enabled, its request is latched as pending. Among the enabled pending lines, a selector picks one winner: the highest level wins, and on a tie the lowest-numbered line wins. Software reads the winner's number from a status register, writes it back to a vector register, and finishes with a write to a level-acknowledge register.

Every writable register answers at four word addresses inside its 16-byte slot. The slot offset selects how the write data combines with the current value: plain store, bitwise OR, bitwise clear, or bitwise exclusive-or. Software can therefore mask or unmask a single line without a read-modify-write. A separate pending-clear region holds one bit per line. Writing a one there discards a latched request, which is how a stale request is dropped before a line is unmasked again. A global enable bit gates the CPU output. The output also stays low from the status read that claims a request until the acknowledge, so only one request is ever in service.

Top module: `icol_collector`

## Requirements
- R1: After reset every control word, the global enable, the vector register and every pending latch read zero, and irq_o is low.
- R2: Line n owns bits [8*(n%4)+7 : 8*(n%4)] of the control word at byte address 0x200 + 0x10*(n/4). Inside that field, bit 2 is the enable and bits 1:0 are the priority level. The other field bits are stored and read back.
- R3: Inside each register slot, the byte offset selects the write action: 0x0 stores the data, 0x4 ORs it in, 0x8 clears the bits that are one in the data, and 0xC inverts them. A read at any of the four offsets returns the register.
- R4: A pending latch sets one cycle after its line is high while enabled, and stays set after the line falls or is masked. A line that is high while masked never latches. An enabled line with a latched request is active even if the line is now low.
- R5: The pending region word j at byte address 0x400 + 0x10*j reads the latches of lines 32*j to 32*j+31, with line n at bit n%32. Writing a one to a bit clears that latch, whatever the slot offset. A clear wins over a set in the same cycle.
- R6: The status register at byte 0x030 returns {bit 31 = an active line exists, bits 6:0 = winning line}. The winner is the active line with the highest level, and on a tie the lowest number. With no active line the register reads zero.
- R7: The global enable is bit 0 of the register at byte 0x020 (aliases apply). irq_o is high only while this bit is set, a winner exists and no request is in service.
- R8: A status read that returns a winner starts service, and irq_o is low from the next cycle. A write to byte 0x010 with bit 0 set ends service, accepted at any time. A write there with bit 0 clear is ignored.
- R9: The vector register at byte 0x000 stores bits 6:0 of the written data (aliases apply) and reads them back with the upper bits zero.
- R10: Read data appears on rdata_o in the cycle after rd_en_i and is zero in every other cycle. Unmapped addresses read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 10 | Word address (byte address bits 11:2) |
| wr_en_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rd_en_i | input | 1 | Read strobe |
| rdata_o | output | 32 | Registered read data |
| src_i | input | 128 | Level request lines, one per source |
| irq_o | output | 1 | Interrupt request to the CPU |

## Verification
The properties assume the two strobes never reach the same register in the same cycle, so a status read and an acknowledge never coincide. They also assume the request lines are synchronous to the clock. The stimulus drives at most one strobe per transaction, always on the falling edge. It changes the request lines only between transactions, and it waits several idle cycles before it samples irq_o. Each status read that claims a winner is followed by an acknowledge, so the service flag never carries from one scenario into the next.

// File: rtl/icol_pkg.sv
`timescale 1ns/1ps
package icol_pkg;

   localparam int unsigned WORD_W = 32;
   localparam int unsigned LANE_W = 8;
   localparam int unsigned LANES  = WORD_W / LANE_W;
   localparam int unsigned EN_POS = 2;
   localparam int unsigned PRIO_W = 2;

   localparam int unsigned GRP_VECTOR = 0;
   localparam int unsigned GRP_LVLACK = 1;
   localparam int unsigned GRP_GCTRL  = 2;
   localparam int unsigned GRP_STAT   = 3;

   typedef enum logic [1:0] {
      ALIAS_STORE = 2'd0,
      ALIAS_OR    = 2'd1,
      ALIAS_ANDN  = 2'd2,
      ALIAS_XOR   = 2'd3
   } alias_e;

   typedef enum logic [2:0] {
      RG_NONE   = 3'd0,
      RG_VECTOR = 3'd1,
      RG_LVLACK = 3'd2,
      RG_GCTRL  = 3'd3,
      RG_STAT   = 3'd4,
      RG_SRCCTL = 3'd5,
      RG_PCLR   = 3'd6
   } region_e;

   function automatic logic alias_bit(alias_e op, logic cur, logic wd);
      logic r;
      case (op)
         ALIAS_STORE: r = wd;
         ALIAS_OR:    r = cur | wd;
         ALIAS_ANDN:  r = cur & ~wd;
         default:     r = cur ^ wd;
      endcase
      return r;
   endfunction

   function automatic logic [WORD_W-1:0] alias_word(alias_e op,
                                                    logic [WORD_W-1:0] cur,
                                                    logic [WORD_W-1:0] wd);
      logic [WORD_W-1:0] r;
      for (int b = 0; b < WORD_W; b++) r[b] = alias_bit(op, cur[b], wd[b]);
      return r;
   endfunction

endpackage

// File: rtl/icol_decode.sv
`timescale 1ns/1ps
module icol_decode import icol_pkg::*; #(
   parameter int unsigned ADDR_W      = 12,
   parameter int unsigned CTL_IW      = 5,
   parameter int unsigned PCLR_IW     = 2,
   parameter int unsigned CTL_BASE_G  = 32,
   parameter int unsigned PCLR_BASE_G = 64
) (
   input  logic [ADDR_W-1:2]  addr_i,
   output region_e            region_o,
   output alias_e             op_o,
   output logic [CTL_IW-1:0]  ctl_idx_o,
   output logic [PCLR_IW-1:0] pclr_idx_o
);

   localparam int unsigned GRP_W = ADDR_W - 4;

   logic [GRP_W-1:0] grp;
   logic             hit_ctl;
   logic             hit_pclr;

   assign grp        = addr_i[ADDR_W-1:4];
   assign op_o       = alias_e'(addr_i[3:2]);
   assign ctl_idx_o  = grp[CTL_IW-1:0];
   assign pclr_idx_o = grp[PCLR_IW-1:0];

   // Each indexed region is aligned to its own size, so the upper group
   // bits name the region and the lower bits index into it.
   assign hit_ctl  = (grp[GRP_W-1:CTL_IW]
                      == (GRP_W-CTL_IW)'(CTL_BASE_G >> CTL_IW));
   assign hit_pclr = (grp[GRP_W-1:PCLR_IW]
                      == (GRP_W-PCLR_IW)'(PCLR_BASE_G >> PCLR_IW));

   always_comb begin
      region_o = RG_NONE;
      if (hit_ctl)                          region_o = RG_SRCCTL;
      else if (hit_pclr)                    region_o = RG_PCLR;
      else if (grp == GRP_W'(GRP_VECTOR))   region_o = RG_VECTOR;
      else if (grp == GRP_W'(GRP_LVLACK))   region_o = RG_LVLACK;
      else if (grp == GRP_W'(GRP_GCTRL))    region_o = RG_GCTRL;
      else if (grp == GRP_W'(GRP_STAT))     region_o = RG_STAT;
   end

endmodule

// File: rtl/icol_ctl_bank.sv
`timescale 1ns/1ps
module icol_ctl_bank import icol_pkg::*; #(
   parameter int unsigned NUM_SRC = 128,
   parameter int unsigned CTL_IW  = 5
) (
   input  logic                                   clk_i,
   input  logic                                   rst_ni,
   input  logic                                   wr_i,
   input  alias_e                                 op_i,
   input  logic [CTL_IW-1:0]                      idx_i,
   input  logic [WORD_W-1:0]                      wdata_i,
   output logic [NUM_SRC/LANES-1:0][WORD_W-1:0]   words_o,
   output logic [NUM_SRC-1:0]                     en_o,
   output logic [NUM_SRC-1:0][PRIO_W-1:0]         prio_o
);

   localparam int unsigned NUM_CTL = NUM_SRC / LANES;

   logic [NUM_CTL-1:0][WORD_W-1:0] word_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         word_q <= '0;
      end else if (wr_i) begin
         for (int w = 0; w < NUM_CTL; w++) begin
            if (idx_i == CTL_IW'(w)) word_q[w] <= alias_word(op_i, word_q[w], wdata_i);
         end
      end
   end

   assign words_o = word_q;

   for (genvar s = 0; s < NUM_SRC; s++) begin : g_field
      localparam int unsigned WI = s / LANES;
      localparam int unsigned LB = (s % LANES) * LANE_W;
      assign en_o[s]   = word_q[WI][LB + EN_POS];
      assign prio_o[s] = word_q[WI][LB +: PRIO_W];
   end

endmodule

// File: rtl/icol_pend_bank.sv
`timescale 1ns/1ps
module icol_pend_bank import icol_pkg::*; #(
   parameter int unsigned NUM_SRC = 128,
   parameter int unsigned PCLR_IW = 2
) (
   input  logic                                   clk_i,
   input  logic                                   rst_ni,
   input  logic [NUM_SRC-1:0]                     src_i,
   input  logic [NUM_SRC-1:0]                     en_i,
   input  logic                                   clr_wr_i,
   input  logic [PCLR_IW-1:0]                     idx_i,
   input  logic [WORD_W-1:0]                      wdata_i,
   output logic [NUM_SRC-1:0]                     pend_o,
   output logic [NUM_SRC/WORD_W-1:0][WORD_W-1:0]  words_o
);

   logic [NUM_SRC-1:0] pend_q;
   logic [NUM_SRC-1:0] clr_mask;

   for (genvar s = 0; s < NUM_SRC; s++) begin : g_clr
      assign clr_mask[s] = clr_wr_i && (idx_i == PCLR_IW'(s / WORD_W))
                           && wdata_i[s % WORD_W];
   end

   // Latch while enabled; a clear in the same cycle takes precedence.
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pend_q <= '0;
      else         pend_q <= (pend_q | (src_i & en_i)) & ~clr_mask;
   end

   assign pend_o  = pend_q;
   assign words_o = pend_q;

endmodule

// File: rtl/icol_select.sv
`timescale 1ns/1ps
module icol_select import icol_pkg::*; #(
   parameter int unsigned NUM_SRC   = 128,
   parameter int unsigned ID_W      = 7,
   parameter bit          PRIO_RANK = 1'b1
) (
   input  logic [NUM_SRC-1:0]             act_i,
   input  logic [NUM_SRC-1:0][PRIO_W-1:0] prio_i,
   output logic                           valid_o,
   output logic [ID_W-1:0]                id_o
);

   logic [NUM_SRC-1:0][PRIO_W-1:0] lvl;

   if (PRIO_RANK) begin : g_ranked
      assign lvl = prio_i;
   end else begin : g_flat
      logic unused_prio;
      assign unused_prio = ^prio_i;
      assign lvl = '0;
   end

   // Scan from the top down; ">=" lets a lower index take over a tie.
   always_comb begin
      logic              found;
      logic [PRIO_W-1:0] best;
      found = 1'b0;
      best  = '0;
      id_o  = '0;
      for (int i = NUM_SRC - 1; i >= 0; i--) begin
         if (act_i[i] && (!found || lvl[i] >= best)) begin
            found = 1'b1;
            best  = lvl[i];
            id_o  = ID_W'(i);
         end
      end
      valid_o = found;
   end

endmodule

// File: rtl/icol_collector.sv
`timescale 1ns/1ps
module icol_collector import icol_pkg::*; #(
   parameter int unsigned NUM_SRC   = 128,
   parameter int unsigned ADDR_W    = 12,
   parameter bit          PRIO_RANK = 1'b1
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic [ADDR_W-1:2]   addr_i,
   input  logic                wr_en_i,
   input  logic [WORD_W-1:0]   wdata_i,
   input  logic                rd_en_i,
   output logic [WORD_W-1:0]   rdata_o,
   input  logic [NUM_SRC-1:0]  src_i,
   output logic                irq_o
);

   localparam int unsigned ID_W        = $clog2(NUM_SRC);
   localparam int unsigned NUM_CTL     = NUM_SRC / LANES;
   localparam int unsigned NUM_PCLR    = NUM_SRC / WORD_W;
   localparam int unsigned CTL_IW      = $clog2(NUM_CTL);
   localparam int unsigned PCLR_IW     = $clog2(NUM_PCLR);
   localparam int unsigned CTL_BASE_G  = (NUM_CTL > 16) ? NUM_CTL : 16;
   localparam int unsigned PCLR_BASE_G = 2 * CTL_BASE_G;
   localparam int unsigned GRP_W       = ADDR_W - 4;

   if (NUM_SRC < 64 || (NUM_SRC & (NUM_SRC - 1)) != 0) begin : g_bad_count
      $error("icol_collector: NUM_SRC must be a power of two, at least 64");
   end
   if (ADDR_W < 8 || (PCLR_BASE_G + NUM_PCLR) > (1 << GRP_W)) begin : g_bad_addr
      $error("icol_collector: ADDR_W too small for the register map");
   end

   region_e                        region;
   alias_e                         op;
   logic [CTL_IW-1:0]              ctl_idx;
   logic [PCLR_IW-1:0]             pclr_idx;
   logic [NUM_CTL-1:0][WORD_W-1:0] ctl_words;
   logic [NUM_PCLR-1:0][WORD_W-1:0] pclr_words;
   logic [NUM_SRC-1:0]             en_vec;
   logic [NUM_SRC-1:0][PRIO_W-1:0] prio_vec;
   logic [NUM_SRC-1:0]             pend;
   logic [NUM_SRC-1:0]             active;
   logic                           sel_valid;
   logic [ID_W-1:0]                sel_id;

   logic                           gen_en;
   logic                           gen_d;
   logic [ID_W-1:0]                vec_q;
   logic [ID_W-1:0]                vec_d;
   logic                           in_svc;
   logic                           stat_rd;
   logic                           ack_wr;
   logic [WORD_W-1:0]              rd_mux;
   logic [WORD_W-1:0]              stat_word;

   icol_decode #(
      .ADDR_W      (ADDR_W),
      .CTL_IW      (CTL_IW),
      .PCLR_IW     (PCLR_IW),
      .CTL_BASE_G  (CTL_BASE_G),
      .PCLR_BASE_G (PCLR_BASE_G)
   ) u_dec (
      .addr_i     (addr_i),
      .region_o   (region),
      .op_o       (op),
      .ctl_idx_o  (ctl_idx),
      .pclr_idx_o (pclr_idx)
   );

   icol_ctl_bank #(
      .NUM_SRC (NUM_SRC),
      .CTL_IW  (CTL_IW)
   ) u_ctl (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_i    (wr_en_i && region == RG_SRCCTL),
      .op_i    (op),
      .idx_i   (ctl_idx),
      .wdata_i (wdata_i),
      .words_o (ctl_words),
      .en_o    (en_vec),
      .prio_o  (prio_vec)
   );

   icol_pend_bank #(
      .NUM_SRC (NUM_SRC),
      .PCLR_IW (PCLR_IW)
   ) u_pend (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .src_i    (src_i),
      .en_i     (en_vec),
      .clr_wr_i (wr_en_i && region == RG_PCLR),
      .idx_i    (pclr_idx),
      .wdata_i  (wdata_i),
      .pend_o   (pend),
      .words_o  (pclr_words)
   );

   assign active = pend & en_vec;

   icol_select #(
      .NUM_SRC   (NUM_SRC),
      .ID_W      (ID_W),
      .PRIO_RANK (PRIO_RANK)
   ) u_sel (
      .act_i   (active),
      .prio_i  (prio_vec),
      .valid_o (sel_valid),
      .id_o    (sel_id)
   );

   assign stat_rd = rd_en_i && region == RG_STAT;
   assign ack_wr  = wr_en_i && region == RG_LVLACK && wdata_i[0];
   assign gen_d   = alias_bit(op, gen_en, wdata_i[0]);

   always_comb begin
      for (int b = 0; b < ID_W; b++) vec_d[b] = alias_bit(op, vec_q[b], wdata_i[b]);
   end

   assign stat_word = {sel_valid, {(WORD_W-1-ID_W){1'b0}}, sel_id};

   always_comb begin
      case (region)
         RG_VECTOR: rd_mux = {{(WORD_W-ID_W){1'b0}}, vec_q};
         RG_GCTRL:  rd_mux = {{(WORD_W-1){1'b0}}, gen_en};
         RG_STAT:   rd_mux = stat_word;
         RG_SRCCTL: rd_mux = ctl_words[ctl_idx];
         RG_PCLR:   rd_mux = pclr_words[pclr_idx];
         default:   rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         gen_en  <= 1'b0;
         vec_q   <= '0;
         in_svc  <= 1'b0;
         rdata_o <= '0;
      end else begin
         if (wr_en_i && region == RG_GCTRL)  gen_en <= gen_d;
         if (wr_en_i && region == RG_VECTOR) vec_q  <= vec_d;
         if (stat_rd && sel_valid)           in_svc <= 1'b1;
         else if (ack_wr)                    in_svc <= 1'b0;
         rdata_o <= rd_en_i ? rd_mux : '0;
      end
   end

   assign irq_o = gen_en && sel_valid && !in_svc;

endmodule

// File: rtl/icol_collector_chk.sv
`timescale 1ns/1ps
module icol_collector_chk import icol_pkg::*; #(
   parameter int unsigned NUM_SRC = 128,
   parameter int unsigned ID_W    = 7
) (
   input logic                clk_i,
   input logic                rst_ni,
   input logic                wr_en_i,
   input logic                rd_en_i,
   input logic                ack_bit_i,
   input region_e             region_i,
   input logic [WORD_W-1:0]   rdata_i,
   input logic                irq_i,
   input logic [NUM_SRC-1:0]  src_i,
   input logic [NUM_SRC-1:0]  en_i,
   input logic [NUM_SRC-1:0]  pend_i,
   input logic                gen_en_i,
   input logic                in_svc_i,
   input logic                sel_valid_i,
   input logic [ID_W-1:0]     sel_id_i
);

   a_r7_irq_needs_gen: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_i |-> gen_en_i);

   a_r8_quiet_in_service: assert property (@(posedge clk_i) disable iff (!rst_ni)
      in_svc_i |-> !irq_i);

   a_r8_ack_releases: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && region_i == RG_LVLACK && ack_bit_i) |=> !in_svc_i);

   a_r8_claim_by_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(in_svc_i) |-> $past(rd_en_i && region_i == RG_STAT && sel_valid_i));

   a_r6_winner_is_live: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sel_valid_i |-> (en_i[sel_id_i] && pend_i[sel_id_i]));

   a_r4_latch_needs_enabled_line: assert property (@(posedge clk_i) disable iff (!rst_ni)
      1'b1 |=> ((pend_i & ~$past(pend_i) & ~$past(src_i & en_i)) == '0));

   a_r10_idle_read_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !rd_en_i |=> (rdata_i == '0));

endmodule

bind icol_collector icol_collector_chk #(
   .NUM_SRC (NUM_SRC),
   .ID_W    (ID_W)
) u_chk (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .wr_en_i     (wr_en_i),
   .rd_en_i     (rd_en_i),
   .ack_bit_i   (wdata_i[0]),
   .region_i    (region),
   .rdata_i     (rdata_o),
   .irq_i       (irq_o),
   .src_i       (src_i),
   .en_i        (en_vec),
   .pend_i      (pend),
   .gen_en_i    (gen_en),
   .in_svc_i    (in_svc),
   .sel_valid_i (sel_valid),
   .sel_id_i    (sel_id)
);

// File: tb/tb_icol_collector.sv
`timescale 1ns/1ps
module tb_icol_collector;

   localparam int unsigned NS = 128;
   localparam int unsigned AW = 12;

   localparam logic [11:0] A_VEC  = 12'h000;
   localparam logic [11:0] A_ACK  = 12'h010;
   localparam logic [11:0] A_GCTL = 12'h020;
   localparam logic [11:0] A_STAT = 12'h030;
   localparam logic [11:0] A_CTL0 = 12'h200;
   localparam logic [11:0] A_PCL0 = 12'h400;

   typedef struct {
      logic [31:0] exp;
      string       tag;
   } rd_item_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:2] addr = '0;
   logic          wr_en = 1'b0;
   logic [31:0]   wdata = '0;
   logic          rd_en = 1'b0;
   logic [31:0]   rdata;
   logic [NS-1:0] src = '0;
   logic          irq;

   int       n_chk = 0;
   int       n_fail = 0;
   rd_item_t exp_q[$];
   logic     rd_seen = 1'b0;

   always #2.5 clk = ~clk;

   icol_collector #(.NUM_SRC(NS), .ADDR_W(AW)) dut (
      .clk_i   (clk),
      .rst_ni  (rst_n),
      .addr_i  (addr),
      .wr_en_i (wr_en),
      .wdata_i (wdata),
      .rd_en_i (rd_en),
      .rdata_o (rdata),
      .src_i   (src),
      .irq_o   (irq)
   );

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
      end
   endtask

   // Monitor: read data is due one edge after the strobe.
   always @(posedge clk) rd_seen <= rd_en;
   always @(negedge clk) begin
      if (rd_seen && exp_q.size() > 0) begin
         rd_item_t it;
         it = exp_q.pop_front();
         check(it.tag, rdata, it.exp);
      end
   end

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_wr(logic [11:0] ba, logic [31:0] d);
      @(negedge clk);
      addr  = ba[AW-1:2];
      wdata = d;
      wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic bus_rd(logic [11:0] ba, logic [31:0] exp, string tag);
      rd_item_t it;
      it.exp = exp;
      it.tag = tag;
      exp_q.push_back(it);
      @(negedge clk);
      addr  = ba[AW-1:2];
      rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic chk_irq(logic exp, string tag);
      idle(3);
      check(tag, {31'b0, irq}, {31'b0, exp});
   endtask

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog all-requirements actual=running expected=finished");
      summary();
      $finish;
   end

   initial begin
      idle(4);
      rst_n = 1'b1;
      idle(1);

      // R1 reset state
      check("R1 irq after reset", {31'b0, irq}, 32'h0);
      bus_rd(A_GCTL, 32'h0, "R1 global enable reset");
      bus_rd(A_CTL0, 32'h0, "R1 control word reset");
      bus_rd(A_VEC,  32'h0, "R1 vector reset");
      bus_rd(A_PCL0, 32'h0, "R1 pending reset");
      bus_rd(A_STAT, 32'h0, "R6 status with nothing active");
      bus_rd(12'h100, 32'h0, "R10 unmapped read");

      // R3 aliases on control word 1 (lines 4..7), lines held low
      bus_wr(A_CTL0 + 12'h010, 32'h0403_0201);
      bus_rd(A_CTL0 + 12'h010, 32'h0403_0201, "R3 plain store");
      bus_rd(A_CTL0 + 12'h018, 32'h0403_0201, "R3 read through alias");
      bus_wr(A_CTL0 + 12'h014, 32'h0000_0400);
      bus_rd(A_CTL0 + 12'h010, 32'h0403_0601, "R3 OR alias");
      bus_wr(A_CTL0 + 12'h018, 32'h0000_0001);
      bus_rd(A_CTL0 + 12'h010, 32'h0403_0600, "R3 clear alias");
      bus_wr(A_CTL0 + 12'h01C, 32'hFF00_0000);
      bus_rd(A_CTL0 + 12'h010, 32'hFB03_0600, "R3 toggle alias");
      bus_wr(A_CTL0 + 12'h010, 32'h0);
      bus_rd(A_PCL0, 32'h0, "R4 enabled low lines do not latch");

      // R9 vector register
      bus_wr(A_VEC, 32'h0000_0055);
      bus_rd(A_VEC, 32'h0000_0055, "R9 vector store");
      bus_wr(A_VEC + 12'h00C, 32'h0000_000F);
      bus_rd(A_VEC, 32'h0000_005A, "R9 vector toggle");
      bus_wr(A_VEC, 32'hFFFF_FF80);
      bus_rd(A_VEC, 32'h0, "R9 upper bits dropped");

      // R7 global enable aliases
      bus_wr(A_GCTL + 12'h004, 32'h1);
      bus_rd(A_GCTL, 32'h1, "R7 global enable set");
      bus_wr(A_GCTL + 12'h008, 32'h1);
      bus_rd(A_GCTL, 32'h0, "R7 global enable clear");

      // R7/R8 line 5: word 1, lane 1, enable at bit 10
      bus_wr(A_CTL0 + 12'h014, 32'h0000_0400);
      src[5] = 1'b1;
      chk_irq(1'b0, "R7 gated by global enable");
      bus_rd(A_PCL0, 32'h0000_0020, "R4 enabled high line latches");
      bus_wr(A_GCTL + 12'h004, 32'h1);
      chk_irq(1'b1, "R7 irq with global enable");
      bus_rd(A_STAT, 32'h8000_0005, "R6 status names line 5");
      check("R8 irq low after claim", {31'b0, irq}, 32'h0);
      bus_wr(A_VEC, 32'h5);
      bus_wr(A_ACK, 32'h2);
      chk_irq(1'b0, "R8 ack without bit0 ignored");
      bus_wr(A_ACK, 32'h1);
      chk_irq(1'b1, "R8 ack ends service");

      // R4/R5 latch holds and clears
      src[5] = 1'b0;
      chk_irq(1'b1, "R4 latch holds after line falls");
      bus_wr(A_PCL0, 32'h0000_0020);
      chk_irq(1'b0, "R5 pending clear drops request");
      bus_rd(A_PCL0, 32'h0, "R5 latch reads cleared");

      // R4 stale latch across a mask, dropped by clear before unmask
      src[5] = 1'b1;
      idle(3);
      bus_wr(A_CTL0 + 12'h018, 32'h0000_0400);
      src[5] = 1'b0;
      chk_irq(1'b0, "R4 masked latch inactive");
      bus_rd(A_PCL0, 32'h0000_0020, "R4 latch kept while masked");
      bus_wr(A_PCL0 + 12'h008, 32'h0000_0020);
      bus_wr(A_CTL0 + 12'h014, 32'h0000_0400);
      chk_irq(1'b0, "R5 clear before unmask");
      bus_rd(A_PCL0, 32'h0, "R5 clear via alias offset");

      // R4 stale latch fires when unmasked without a clear
      src[5] = 1'b1;
      idle(3);
      bus_wr(A_CTL0 + 12'h018, 32'h0000_0400);
      src[5] = 1'b0;
      bus_wr(A_CTL0 + 12'h014, 32'h0000_0400);
      chk_irq(1'b1, "R4 stale latch fires on unmask");
      bus_wr(A_PCL0, 32'h0000_0020);
      bus_wr(A_CTL0 + 12'h018, 32'h0000_0400);
      chk_irq(1'b0, "R5 cleanup line 5");

      // R4 masked high line never latches (line 20)
      src[20] = 1'b1;
      idle(3);
      bus_rd(A_PCL0, 32'h0, "R4 masked line does not latch");
      src[20] = 1'b0;

      // R6 tie: lines 3 and 9 at level 0
      bus_wr(A_CTL0 + 12'h004, 32'h0400_0000);
      bus_wr(A_CTL0 + 12'h024, 32'h0000_0400);
      src[3] = 1'b1;
      src[9] = 1'b1;
      idle(3);
      bus_rd(A_STAT, 32'h8000_0003, "R6 tie goes to lowest line");
      bus_wr(A_ACK, 32'h1);
      bus_wr(A_CTL0 + 12'h024, 32'h0000_0200);
      bus_rd(A_CTL0 + 12'h020, 32'h0000_0600, "R2 line 9 field layout");
      bus_rd(A_STAT, 32'h8000_0009, "R6 higher level wins");
      bus_wr(A_ACK, 32'h1);

      // R2 top line 127: word 31 at 0x3F0, lane 3, enable + level 3
      bus_wr(A_CTL0 + 12'h1F4, 32'h0700_0000);
      src[127] = 1'b1;
      idle(3);
      bus_rd(A_STAT, 32'h8000_007F, "R2 line 127 selected at level 3");
      bus_rd(A_PCL0 + 12'h030, 32'h8000_0000, "R5 pending word 3 bit 31");
      bus_wr(A_ACK, 32'h1);

      // Tear down: nothing active
      src = '0;
      bus_wr(A_CTL0 + 12'h004, 32'h0);
      bus_wr(A_CTL0 + 12'h020, 32'h0);
      bus_wr(A_CTL0 + 12'h1F0, 32'h0);
      for (int j = 0; j < 4; j++) bus_wr(A_PCL0 + 12'(16 * j), 32'hFFFF_FFFF);
      chk_irq(1'b0, "R7 irq low with nothing active");
      bus_rd(A_STAT, 32'h0, "R6 status clear after teardown");
      idle(2);
      check("R10 read data zero when idle", rdata, 32'h0);

      while (exp_q.size() > 0) @(negedge clk);
      idle(2);
      summary();
      $finish;
   end

endmodule